// File: doc/BRIEF.md
# Interprocessor and Arbitration Control Register

A 64-bit control and status register shared by four CPUs. It holds one interprocessor interrupt flag and one interval timer interrupt flag per CPU, two four-bit arbitration status fields, and a small general-purpose field. Each field group has its own write rule: some bits clear when a 1 is written, some set when a 1 is written, one field accepts ones only while it is empty, one command bit wipes the arbitration fields first, and a group of request bits raises the interprocessor flags.

Software writes the whole word in one access. Reads are combinational, and the two lowest bits hold the index of the CPU that makes the access. A timer block outside this one raises the timer flags through per-CPU set inputs. The block drives a level per CPU for the interprocessor interrupt, and a one-cycle clear pulse per CPU when software clears that CPU's timer flag.

Top module: `misc_ctl_reg`

## Requirements
- R1: After reset every stored bit is zero, `ipi_lvl` is 0 and `tmr_clr` is 0.
- R2: `rd_data[1:0]` always equals `req_cpu`. The other bits show the stored fields.
- R3: A write with 1 in bit 4+i clears timer flag i (bits 7:4). A write with 1 in bit 8+i clears interprocessor flag i (bits 11:8). Bit 28 is also write-1-to-clear, and because nothing in this block sets it, it reads 0.
- R4: A write with bit 20 set clears bits 23:16 before the set rules of R5 and R6 apply to that same write.
- R5: Bits 23:20 are write-1-to-set. A 0 written there leaves the bit unchanged.
- R6: Bits 19:16 take the written ones only if the field is all zero at that point, after any R4 clear. Otherwise the field keeps its value.
- R7: A write with 1 in bit 12+i sets interprocessor flag i (bit 8+i). Within one write, this set overrides a clear of the same flag under R3.
- R8: Bits 43:40 take the written value on every write.
- R9: `tmr_set[i]` high sets timer flag i (bit 4+i) at the next edge. In a cycle with both a set and a software clear of that flag, the set wins.
- R10: `ipi_lvl[i]` always equals interprocessor flag i (bit 8+i).
- R11: `tmr_clr[i]` is high for exactly the one cycle after a write that has 1 in bit 4+i while `tmr_set[i]` is low. At all other times it is low.
- R12: Every bit outside 43:40, 23:16, 11:4 and 1:0 reads 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a full 64-bit word |
| wr_data | input | 64 | Write data |
| req_cpu | input | 2 | Index of the CPU making the access |
| tmr_set | input | 4 | Per-CPU timer flag set, from the timer block |
| rd_data | output | 64 | Register contents with `req_cpu` merged in bits 1:0 |
| ipi_lvl | output | 4 | Per-CPU interprocessor interrupt level |
| tmr_clr | output | 4 | Per-CPU timer interrupt clear pulse |

## Verification
The assertions assume that `wr_en`, `wr_data`, `req_cpu` and `tmr_set` are known and stable around each rising edge. They also assume that a write and a timer set may land in the same cycle, on the same flag or on different ones. The bench changes inputs only on falling edges and holds `wr_en` low during reset. Directed steps place a timer set and a software clear of the same flag in one cycle, and put a request and a clear of the same interprocessor flag in one write. A random phase follows that includes the clear command together with arbitration writes.

// File: rtl/misc_ctl_pkg.sv
package misc_ctl_pkg;
  localparam int CPUS      = 4;
  localparam int DW        = 64;
  localparam int ID_W      = $clog2(CPUS);
  localparam int ITI_LSB   = 4;
  localparam int IPI_LSB   = ITI_LSB + CPUS;
  localparam int REQ_LSB   = IPI_LSB + CPUS;
  localparam int ARB_W     = 4;
  localparam int OWN_LSB   = 16;
  localparam int TAKE_LSB  = OWN_LSB + ARB_W;
  localparam int WIPE_BIT  = TAKE_LSB;
  localparam int USER_LSB  = 40;
  localparam int USER_W    = 4;
endpackage

// File: rtl/misc_cpu_lane.sv
module misc_cpu_lane (
  input  logic wr_en,
  input  logic wclr_iti,
  input  logic wclr_ipi,
  input  logic req_ipi,
  input  logic hw_set,
  input  logic iti_q,
  input  logic ipi_q,
  output logic iti_d,
  output logic ipi_d,
  output logic clr_d
);
  logic sw_clr_iti;
  logic sw_clr_ipi;
  logic sw_req;

  always_comb begin
    sw_clr_iti = wr_en & wclr_iti;
    sw_clr_ipi = wr_en & wclr_ipi;
    sw_req     = wr_en & req_ipi;
    // hardware set wins over a simultaneous software clear
    iti_d      = (iti_q & ~sw_clr_iti) | hw_set;
    // request applied after the clear
    ipi_d      = (ipi_q & ~sw_clr_ipi) | sw_req;
    clr_d      = sw_clr_iti & ~hw_set;
  end
endmodule

// File: rtl/misc_arb_next.sv
module misc_arb_next #(
  parameter int W = 4
) (
  input  logic         wr_en,
  input  logic         wipe,
  input  logic [W-1:0] wr_take,
  input  logic [W-1:0] wr_own,
  input  logic [W-1:0] take_q,
  input  logic [W-1:0] own_q,
  output logic [W-1:0] take_d,
  output logic [W-1:0] own_d
);
  logic [W-1:0] take_base;
  logic [W-1:0] own_base;

  always_comb begin
    take_base = (wr_en && wipe) ? '0 : take_q;
    own_base  = (wr_en && wipe) ? '0 : own_q;
    take_d    = take_base;
    own_d     = own_base;
    if (wr_en) begin
      take_d = take_base | wr_take;
      if (own_base == '0) begin
        own_d = wr_own;
      end
    end
  end
endmodule

// File: rtl/misc_ctl_reg.sv
module misc_ctl_reg
  import misc_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic [ID_W-1:0] req_cpu,
  input  logic [CPUS-1:0] tmr_set,
  output logic [DW-1:0]   rd_data,
  output logic [CPUS-1:0] ipi_lvl,
  output logic [CPUS-1:0] tmr_clr
);
  logic [CPUS-1:0]   iti_q, iti_d;
  logic [CPUS-1:0]   ipi_q, ipi_d;
  logic [CPUS-1:0]   clr_q, clr_d;
  logic [ARB_W-1:0]  take_q, take_d;
  logic [ARB_W-1:0]  own_q, own_d;
  logic [USER_W-1:0] user_q, user_d;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[DW-1:USER_LSB+USER_W],
                            wr_data[USER_LSB-1:TAKE_LSB+ARB_W],
                            wr_data[ITI_LSB-1:0]};

  for (genvar g = 0; g < CPUS; g++) begin : g_lane
    misc_cpu_lane u_lane (
      .wr_en    (wr_en),
      .wclr_iti (wr_data[ITI_LSB+g]),
      .wclr_ipi (wr_data[IPI_LSB+g]),
      .req_ipi  (wr_data[REQ_LSB+g]),
      .hw_set   (tmr_set[g]),
      .iti_q    (iti_q[g]),
      .ipi_q    (ipi_q[g]),
      .iti_d    (iti_d[g]),
      .ipi_d    (ipi_d[g]),
      .clr_d    (clr_d[g])
    );
  end

  misc_arb_next #(.W(ARB_W)) u_arb (
    .wr_en   (wr_en),
    .wipe    (wr_data[WIPE_BIT]),
    .wr_take (wr_data[TAKE_LSB +: ARB_W]),
    .wr_own  (wr_data[OWN_LSB +: ARB_W]),
    .take_q  (take_q),
    .own_q   (own_q),
    .take_d  (take_d),
    .own_d   (own_d)
  );

  always_comb begin
    user_d = wr_data[USER_LSB +: USER_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iti_q  <= '0;
      ipi_q  <= '0;
      clr_q  <= '0;
      take_q <= '0;
      own_q  <= '0;
    end else begin
      iti_q  <= iti_d;
      ipi_q  <= ipi_d;
      clr_q  <= clr_d;
      take_q <= take_d;
      own_q  <= own_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_q <= '0;
    end else if (wr_en) begin
      user_q <= user_d;
    end
  end

  always_comb begin
    rd_data                        = '0;
    rd_data[ID_W-1:0]              = req_cpu;
    rd_data[ITI_LSB +: CPUS]       = iti_q;
    rd_data[IPI_LSB +: CPUS]       = ipi_q;
    rd_data[OWN_LSB +: ARB_W]      = own_q;
    rd_data[TAKE_LSB +: ARB_W]     = take_q;
    rd_data[USER_LSB +: USER_W]    = user_q;
  end

  assign ipi_lvl = ipi_q;
  assign tmr_clr = clr_q;
endmodule

// File: rtl/misc_ctl_reg_chk.sv
module misc_ctl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [63:0] wr_data,
  input logic [1:0]  req_cpu,
  input logic [3:0]  tmr_set,
  input logic [63:0] rd_data,
  input logic [3:0]  ipi_lvl,
  input logic [3:0]  tmr_clr
);
  localparam logic [63:0] LIVE = 64'h0000_0F00_00FF_0FF3;

  AST_ID_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] == req_cpu); // R2
  AST_TAKE_W1S: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data[23:20] & $past(wr_data[23:20])) == $past(wr_data[23:20]))); // R5
  AST_OWN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[20] && rd_data[19:16] != 4'h0) |=> (rd_data[19:16] == $past(rd_data[19:16]))); // R6
  AST_REQ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ipi_lvl & $past(wr_data[15:12])) == $past(wr_data[15:12]))); // R7
  AST_USER_RW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[43:40] == $past(wr_data[43:40]))); // R8
  AST_TMR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_set != 4'h0) |=> ((rd_data[7:4] & $past(tmr_set)) == $past(tmr_set))); // R9
  AST_IPI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_lvl == rd_data[11:8]); // R10
  AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_clr != 4'h0) |-> $past(wr_en)); // R11
  AST_DEAD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE) == 64'h0); // R12
endmodule

bind misc_ctl_reg misc_ctl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .req_cpu(req_cpu), .tmr_set(tmr_set), .rd_data(rd_data),
  .ipi_lvl(ipi_lvl), .tmr_clr(tmr_clr)
);

// File: tb/misc_ctl_reg_bench.sv
module misc_ctl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [1:0]  req_cpu = '0;
  logic [3:0]  tmr_set = '0;
  logic [63:0] rd_data;
  logic [3:0]  ipi_lvl;
  logic [3:0]  tmr_clr;

  int checks = 0;
  int errors = 0;
  logic [63:0] m;
  logic [3:0]  m_clr;

  always #10 clk = ~clk;

  misc_ctl_reg u_misc_ctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .req_cpu(req_cpu), .tmr_set(tmr_set), .rd_data(rd_data),
    .ipi_lvl(ipi_lvl), .tmr_clr(tmr_clr)
  );

  // behavioural reference, one update per rising edge
  always @(posedge clk or negedge rst_n) begin
    logic [63:0] n;
    logic [3:0]  c;
    if (!rst_n) begin
      m = '0; m_clr = '0;
    end else begin
      n = m; c = '0;
      if (wr_en) begin
        n = n & ~(wr_data & 64'h0000_0000_1000_0FF0);
        if (wr_data[20]) n[23:16] = 8'h00;
        n[23:20] = n[23:20] | wr_data[23:20];
        if (n[19:16] == 4'h0) n[19:16] = wr_data[19:16];
        n[11:8]  = n[11:8] | wr_data[15:12];
        n[43:40] = wr_data[43:40];
        c = wr_data[7:4] & ~tmr_set;
      end
      n[7:4] = n[7:4] | tmr_set;
      m = n; m_clr = c;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    logic [63:0] e;
    e = m | {62'h0, req_cpu};
    chk("R2 id bits",       {62'h0, rd_data[1:0]},   {62'h0, e[1:0]});
    chk("R9 R3 iti field",  {60'h0, rd_data[7:4]},   {60'h0, e[7:4]});
    chk("R7 R3 ipi field",  {60'h0, rd_data[11:8]},  {60'h0, e[11:8]});
    chk("R4 R5 R6 arb",     {56'h0, rd_data[23:16]}, {56'h0, e[23:16]});
    chk("R8 user field",    {60'h0, rd_data[43:40]}, {60'h0, e[43:40]});
    chk("R12 dead bits",    rd_data & ~64'h0000_0F00_00FF_0FF3, 64'h0);
    chk("R10 ipi_lvl",      {60'h0, ipi_lvl}, {60'h0, e[11:8]});
    chk("R11 tmr_clr",      {60'h0, tmr_clr}, {60'h0, m_clr});
  endtask

  task automatic step(input logic we, input logic [63:0] d, input logic [3:0] ts);
    wr_en = we; wr_data = d; tmr_set = ts;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; tmr_set = '0;
    cmp_model();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rd_data", rd_data, 64'h0);
    chk("R1 reset outputs", {56'h0, ipi_lvl, tmr_clr}, 64'h0);
    cmp_model();

    step(1'b0, 64'h0, 4'b0101);
    chk("R9 timer set", {60'h0, rd_data[7:4]}, 64'h5);
    step(1'b1, 64'h0000_0000_0000_00F0, 4'b0001);
    chk("R9 set beats clear", {60'h0, rd_data[7:4]}, 64'h1);
    chk("R11 clear pulse", {60'h0, tmr_clr}, 64'hE);
    step(1'b0, 64'h0, 4'b0000);
    chk("R11 pulse one cycle", {60'h0, tmr_clr}, 64'h0);
    step(1'b1, 64'h0000_0000_0000_A000, 4'b0000);
    chk("R7 request sets ipi", {60'h0, ipi_lvl}, 64'hA);
    step(1'b1, 64'h0000_0000_0000_1200, 4'b0000);
    chk("R3 R7 clear and request", {60'h0, ipi_lvl}, 64'h9);
    step(1'b1, 64'h0000_0000_0003_0000, 4'b0000);
    chk("R6 own takes when empty", {60'h0, rd_data[19:16]}, 64'h3);
    step(1'b1, 64'h0000_0000_000C_0000, 4'b0000);
    chk("R6 own holds when busy", {60'h0, rd_data[19:16]}, 64'h3);
    step(1'b1, 64'h0000_0000_0040_0000, 4'b0000);
    chk("R5 take w1s", {60'h0, rd_data[23:20]}, 64'h4);
    step(1'b1, 64'h0000_0000_0018_0000, 4'b0000);
    chk("R4 wipe then set", {56'h0, rd_data[23:16]}, 64'h18);
    step(1'b1, 64'h0000_0A00_0000_0000, 4'b0000);
    chk("R8 user write", {60'h0, rd_data[43:40]}, 64'hA);
    req_cpu = 2'd2;
    step(1'b1, 64'hFFFF_F0FF_F000_000F, 4'b0000);
    chk("R12 R2 R3 full word", rd_data, 64'h0000_0000_0018_0912);

    for (int i = 0; i < 400; i++) begin
      req_cpu = 2'($urandom);
      step(($urandom % 3) != 0, {$urandom, $urandom}, 4'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule